// File: doc/BRIEF.md
# Sequence-Locked Watchdog Timer

This block is a watchdog timer driven by a slow timer tick that arrives as a one-cycle pulse `tick_in` in the fast clock domain. An up-counter advances on a prescaled version of that tick while the watchdog runs. Software reaches the block through a single-cycle write port and a combinational read port that together select one of seven word registers. When the counter passes its all-ones value, the block raises `wd_reset_out` for one tick period and reloads the counter, so a system reset controller can act on it.

Software can start or stop the timer only by writing a matched pair of key words, in order, to the run-control register. Software keeps the timer from expiring by writing the trigger register with a value that differs from the last one applied. The usual way is to alternate a pattern and its complement. Every write to a register that has side effects is posted into the tick domain. A pending flag in the status register tracks the write until it takes effect two ticks later, and a second write to the same register in that window is dropped.

Top module: `seqwd_top`

## Requirements
- R1: The run state is visible in bit 0 of the run-control register (address 5). It resets to 0 and becomes 1 once the word 0x0000BBBB is applied to that register and the word 0x00004444 is applied right after it.
- R2: The run state returns to 0 once 0x0000AAAA is applied to the run-control register and 0x00005555 is applied right after it.
- R3: Any other word, or a key word that is not the expected partner, clears the partial sequence and leaves the run state unchanged. Examples are BBBB, 1234, 4444 and BBBB, AAAA, 4444.
- R4: When a trigger write (address 4) is applied with a value that differs from the last applied trigger value, the counter reloads from the load register (address 2). The last applied value resets to 0 and reads back at address 4. Re-applying the same value causes no reload.
- R5: The status register (address 6) shows pending writes in these bits: bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for run-control. A flag rises in the cycle after its write is accepted. It clears on the second later tick, and the write takes effect on that same tick.
- R6: A write to a register whose pending flag is set is ignored.
- R7: In the control register (address 1), bit 5 enables the prescaler and bits 4:2 hold a value P. When enabled, the counter advances on every 2^P-th tick. When disabled, it advances on every tick. Applying a control write restarts the prescale count.
- R8: The counter (address 3, read only) counts upward on the prescaled tick, and only while the run state is 1.
- R9: When a prescaled tick finds the counter at all ones while running, the counter reloads from the load register. `wd_reset_out` is then high from that edge until the next tick edge.
- R10: Address 0 returns the revision code in bits 7:0. Reset clears control, load, counter, trigger and status. Writes to addresses 0, 3 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle pulse per slow timer tick |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 3 | Register select for reads and writes |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the selected register |
| wd_reset_out | output | 1 | Expiry pulse, one tick long |

## Verification
The bench builds the block with an 8-bit counter and a 32-bit data word, and it issues a tick every fourth clock. With these values, a load of 0xF0 reaches overflow within sixteen ticks, so several expiry pulses fit in a short run. The same settings let prescale values 0 and 2 be compared against undivided counting, and posting delays show up within a few clocks. A behavioural model is compared with the selected read word and the reset output on every cycle, while the selected address walks through the status, run-control, trigger and counter registers.

// File: rtl/seqwd_pkg.sv
package seqwd_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_REV   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RUN   = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;

  // posted slots
  localparam int NSLOT  = 4;
  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_TRIG = 2;
  localparam int S_RUN  = 3;

  localparam logic [15:0] K_ARM1 = 16'hBBBB;
  localparam logic [15:0] K_ARM2 = 16'h4444;
  localparam logic [15:0] K_DIS1 = 16'hAAAA;
  localparam logic [15:0] K_DIS2 = 16'h5555;

  localparam int PSC_W = 7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM1, SQ_DIS1} seq_t;

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    case (s)
      S_CTRL:  return A_CTRL;
      S_LOAD:  return A_LOAD;
      S_TRIG:  return A_TRIG;
      default: return A_RUN;
    endcase
  endfunction

  function automatic logic [PSC_W-1:0] presc_mask(input logic [2:0] p);
    logic [PSC_W:0] one_sh;
    one_sh = (PSC_W+1)'(1) << p;
    return PSC_W'(one_sh - 1'b1);
  endfunction

  function automatic logic [7:0] stat_pack(input logic [NSLOT-1:0] b);
    return {3'b000, b[S_RUN], b[S_TRIG], b[S_LOAD], 1'b0, b[S_CTRL]};
  endfunction
endpackage

// File: rtl/seqwd_post.sv
module seqwd_post #(
  parameter int DW = 32,
  parameter int POST_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          fire,
  output logic [DW-1:0] data
);
  localparam int PW = $clog2(POST_TICKS + 1);
  logic [PW-1:0] left_q;

  assign busy = (left_q != '0);
  assign fire = tick && (left_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      data   <= '0;
    end else if (wr_hit && !busy) begin
      left_q <= PW'(POST_TICKS);
      data   <= wdata;
    end else if (tick && busy) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/seqwd_seq.sv
module seqwd_seq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] word,
  output logic          running
);
  import seqwd_pkg::*;
  seq_t st_q;

  function automatic logic is_key(input logic [DW-1:0] w, input logic [15:0] k);
    return w == DW'(k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      running <= 1'b0;
    end else if (fire) begin
      if (is_key(word, K_ARM1))
        st_q <= SQ_ARM1;
      else if (is_key(word, K_DIS1))
        st_q <= SQ_DIS1;
      else begin
        st_q <= SQ_IDLE;
        if (is_key(word, K_ARM2) && st_q == SQ_ARM1) running <= 1'b1;
        if (is_key(word, K_DIS2) && st_q == SQ_DIS1) running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seqwd_prescale.sv
module seqwd_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [2:0] ptv,
  input  logic       restart,
  output logic       ptick
);
  import seqwd_pkg::*;
  logic [PSC_W-1:0] div_q;
  logic             at_end;

  assign at_end = (div_q == presc_mask(ptv));
  assign ptick  = en ? (tick && at_end) : tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (restart)
      div_q <= '0;
    else if (tick && en)
      div_q <= at_end ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/seqwd_count.sv
module seqwd_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ptick,
  input  logic             running,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             rst_out
);
  assign ovf = running && ptick && (cnt == '1) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (reload || ovf)
      cnt <= load_val;
    else if (running && ptick)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_out <= 1'b0;
    else if (ovf)
      rst_out <= 1'b1;
    else if (tick)
      rst_out <= 1'b0;
  end
endmodule

// File: rtl/seqwd_top.sv
module seqwd_top #(
  parameter int DW = 32,
  parameter int CNT_W = 32,
  parameter int POST_TICKS = 2,
  parameter logic [7:0] REV = 8'h21
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_in,
  input  logic                      wr_en,
  input  logic [seqwd_pkg::ADDR_W-1:0] addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic                      wd_reset_out
);
  import seqwd_pkg::*;

  logic [NSLOT-1:0] slot_busy;
  logic [NSLOT-1:0] slot_fire;
  logic [DW-1:0]    slot_data [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    seqwd_post #(.DW(DW), .POST_TICKS(POST_TICKS)) u_post (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_in),
      .wr_hit (wr_en && (addr == slot_addr(s))),
      .wdata  (wdata),
      .busy   (slot_busy[s]),
      .fire   (slot_fire[s]),
      .data   (slot_data[s])
    );
  end

  logic             psc_en_q;
  logic [2:0]       psc_val_q;
  logic [CNT_W-1:0] load_q;
  logic [DW-1:0]    trig_last_q;
  logic             trig_reload;
  logic             running;
  logic             ptick;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_en_q    <= 1'b0;
      psc_val_q   <= '0;
      load_q      <= '0;
      trig_last_q <= '0;
    end else begin
      if (slot_fire[S_CTRL]) begin
        psc_en_q  <= slot_data[S_CTRL][5];
        psc_val_q <= slot_data[S_CTRL][4:2];
      end
      if (slot_fire[S_LOAD]) load_q <= slot_data[S_LOAD][CNT_W-1:0];
      if (slot_fire[S_TRIG]) trig_last_q <= slot_data[S_TRIG];
    end
  end

  assign trig_reload = slot_fire[S_TRIG] && (slot_data[S_TRIG] != trig_last_q);

  seqwd_seq #(.DW(DW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (slot_fire[S_RUN]),
    .word    (slot_data[S_RUN]),
    .running (running)
  );

  seqwd_prescale u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_in),
    .en      (psc_en_q),
    .ptv     (psc_val_q),
    .restart (slot_fire[S_CTRL]),
    .ptick   (ptick)
  );

  seqwd_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_in),
    .ptick    (ptick),
    .running  (running),
    .reload   (trig_reload),
    .load_val (load_q),
    .cnt      (cnt_q),
    .ovf      (ovf_evt),
    .rst_out  (wd_reset_out)
  );

  always_comb begin
    case (addr)
      A_REV:   rdata = DW'(REV);
      A_CTRL:  rdata = DW'({psc_en_q, psc_val_q, 2'b00});
      A_LOAD:  rdata = DW'(load_q);
      A_COUNT: rdata = DW'(cnt_q);
      A_TRIG:  rdata = trig_last_q;
      A_RUN:   rdata = DW'(running);
      A_STAT:  rdata = DW'(stat_pack(slot_busy));
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/seqwd_chk.sv
module seqwd_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_in,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [3:0]       busy,
  input logic [3:0]       fire,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_out
);
  // R5: an accepted control write raises its pending flag
  a_r5_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !busy[0]) |=> busy[0]);

  // R5: a pending flag can only drop on a tick
  a_r5_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[2] && !tick_in) |=> busy[2]);

  // R1: run state changes only when a run-control write is applied
  a_r1_run_needs_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !fire[3] |=> $stable(running));

  // R8: counter moves only on tick edges
  a_r8_cnt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> $stable(cnt));

  // R9: no expiry pulse starts while stopped
  a_r9_no_rst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !rst_out) |=> !rst_out);

  // R9: expiry pulse starts on a tick edge
  a_r9_rst_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out ##1 rst_out) |-> $past(tick_in));
endmodule

bind seqwd_top seqwd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_in (tick_in),
  .wr_en   (wr_en),
  .addr    (addr),
  .busy    (slot_busy),
  .fire    (slot_fire),
  .running (running),
  .cnt     (cnt_q),
  .rst_out (wd_reset_out)
);

// File: tb/seqwd_top_test.sv
module seqwd_top_test;
  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, tick_in = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic wd_reset_out;

  int n_cmp = 0, n_bad = 0;
  string phase = "R10";
  bit done = 0;

  seqwd_top #(.DW(DW), .CNT_W(CW), .POST_TICKS(2), .REV(8'h21)) uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wd_reset_out(wd_reset_out));

  always #5 clk = ~clk;

  // ---------------- behavioural model ----------------
  int m_pl[4];
  int m_pv[4];
  int m_en, m_ptv, m_ps, m_load, m_cnt, m_last, m_run, m_st, m_rst;
  int m_rises = 0, d_rises = 0;

  function automatic int slot_of(input logic [2:0] a);
    case (a)
      3'd1: return 0;
      3'd2: return 1;
      3'd4: return 2;
      3'd5: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pl[i]) begin m_pl[i] = 0; m_pv[i] = 0; end
      m_en = 0; m_ptv = 0; m_ps = 0; m_load = 0; m_cnt = 0;
      m_last = 0; m_run = 0; m_st = 0; m_rst = 0;
    end else begin
      bit f[4];
      bit pt, ov, rel;
      int span, sl;
      for (int i = 0; i < 4; i++) f[i] = tick_in && (m_pl[i] == 1);
      span = 1 << m_ptv;
      pt = m_en ? (tick_in && (m_ps == span - 1)) : tick_in;
      rel = f[2] && (m_pv[2] != m_last);
      ov = 0;
      if (rel) m_cnt = m_load;
      else if (m_run && pt) begin
        if (m_cnt == (1 << CW) - 1) begin m_cnt = m_load; ov = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (ov) begin if (!m_rst) m_rises++; m_rst = 1; end
      else if (tick_in) m_rst = 0;
      if (f[0]) m_ps = 0;
      else if (tick_in && m_en) m_ps = (m_ps + 1) % span;
      if (f[3]) begin
        if (m_pv[3] == 'hBBBB) m_st = 1;
        else if (m_pv[3] == 'hAAAA) m_st = 2;
        else begin
          if (m_pv[3] == 'h4444 && m_st == 1) m_run = 1;
          if (m_pv[3] == 'h5555 && m_st == 2) m_run = 0;
          m_st = 0;
        end
      end
      if (f[0]) begin m_en = (m_pv[0] >> 5) & 1; m_ptv = (m_pv[0] >> 2) & 7; end
      if (f[1]) m_load = m_pv[1] % (1 << CW);
      if (f[2]) m_last = m_pv[2];
      sl = wr_en ? slot_of(addr) : -1;
      for (int i = 0; i < 4; i++) begin
        if (i == sl && m_pl[i] == 0) begin m_pl[i] = 2; m_pv[i] = int'(wdata); end
        else if (tick_in && m_pl[i] > 0) m_pl[i] = m_pl[i] - 1;
      end
    end
  end

  function automatic int expect_rd(input logic [2:0] a);
    case (a)
      3'd0: return 'h21;
      3'd1: return (m_en << 5) | (m_ptv << 2);
      3'd2: return m_load;
      3'd3: return m_cnt;
      3'd4: return m_last;
      3'd5: return m_run;
      3'd6: return ((m_pl[0] > 0) ? 1 : 0) | ((m_pl[1] > 0) ? 4 : 0) |
                   ((m_pl[2] > 0) ? 8 : 0) | ((m_pl[3] > 0) ? 16 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from both edges
  logic prev_rst = 0;
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && !done) begin
        check({phase, " rdata"}, int'(rdata), expect_rd(addr));
        check({phase, " R9 reset_out"}, int'(wd_reset_out), m_rst);
        if (wd_reset_out && !prev_rst) d_rises++;
        prev_rst = wd_reset_out;
      end
    end
  end

  // tick every fourth clock
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      tick_in = (k % 4 == 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d, input logic [2:0] rd);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = DW'(d);
    @(negedge clk);
    wr_en = 0; addr = rd;
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    phase = "R10";
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a); idle(1);
    end
    wr(3'd0, 'hFF, 3'd0); idle(12);
    wr(3'd3, 'h55, 3'd3); idle(12);
    wr(3'd6, 'h1F, 3'd6); idle(12);

    phase = "R5";
    wr(3'd1, 'h00, 3'd6); idle(14);
    wr(3'd2, 'hF0, 3'd6); idle(14);
    wr(3'd4, 'h99, 3'd6); idle(14);
    wr(3'd5, 'h77, 3'd6); idle(14);

    phase = "R6";
    wr(3'd2, 'h10, 3'd6);
    wr(3'd2, 'h20, 3'd2); idle(14);
    wr(3'd2, 'hF0, 3'd2); idle(14);

    phase = "R3";
    wr(3'd5, 'hBBBB, 3'd5); idle(12);
    wr(3'd5, 'h1234, 3'd5); idle(12);
    wr(3'd5, 'h4444, 3'd5); idle(12);
    wr(3'd5, 'hBBBB, 3'd5); idle(12);
    wr(3'd5, 'hAAAA, 3'd5); idle(12);
    wr(3'd5, 'h4444, 3'd3); idle(40);

    phase = "R1";
    wr(3'd5, 'hBBBB, 3'd5); idle(12);
    wr(3'd5, 'h4444, 3'd5); idle(12);
    addr = 3'd3; idle(40);

    phase = "R4";
    wr(3'd4, 'h1234, 3'd3); idle(20);
    wr(3'd4, 'h1234, 3'd3); idle(20);
    wr(3'd4, 'hFFFFEDCB, 3'd4); idle(12);
    addr = 3'd3; idle(20);

    phase = "R9";
    idle(150);

    phase = "R7";
    wr(3'd1, 'h28, 3'd3); idle(300);
    wr(3'd1, 'h20, 3'd1); idle(12);
    addr = 3'd3; idle(100);

    phase = "R2";
    wr(3'd5, 'hAAAA, 3'd5); idle(12);
    wr(3'd5, 'h5555, 3'd5); idle(12);
    phase = "R8";
    addr = 3'd3; idle(80);

    done = 1;
    check("R9 expiry pulses seen", d_rises, m_rises);
    check("R9 at least one expiry", (m_rises > 0) ? 1 : 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule